// File: doc/BRIEF.md
# Quadword Bit-Field Block Transfer Engine

This block copies a run of bits from a 64-bit source quadword into a 64-bit destination quadword. Each quadword is handled as four 16-bit words. Along the way the copied bits are merged with the bits already in the destination, using any of the sixteen two-input Boolean functions. A single start pulse captures both quadwords, the two bit pointers, the run length and the options. After that the engine works through the run one chunk per clock. A chunk never crosses a 16-bit word boundary in either quadword.

For each chunk the engine does the following:
- It extracts the source field and shifts it to the destination bit offset.
- It can force the source bits outside the field to one.
- It can clear the destination bits inside the field.
- It applies the logic function to the whole selected destination word and writes only that word back.

When the run ends, or when either bit pointer wraps back to zero, the engine raises a one-cycle done pulse. The pulse comes with a termination code and the number of chunks processed. The updated destination quadword can be read at any time.

Top module: `bb_engine`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `busy`, `done`, `result` and `loop_cnt` are zero and `dst_out` is all zeros.
- R2: When idle, a `start` pulse captures all inputs. `busy` is 1 and `loop_cnt` is 0 in the following cycle. A `start` seen while `busy` is ignored and does not change the outcome of the run in progress.
- R3: Each clock while busy processes one chunk. The chunk length is the smallest of three values: bits left in the current source word, bits left in the current destination word, and bits left in the run. `loop_cnt` increases by one per chunk.
- R4: A 6-bit pointer selects the word with bits [5:4] and the bit offset with bits [3:0]. Word k occupies `src_qw`/`dst_qw` bits [16k+15:16k], and offset o is bit o of that word, with bit 0 the least significant.
- R5: The result bit is `func[{d,s}]`, where d is the destination bit and s is the aligned source bit. For example, 4'hA copies the source, 4'h8 is AND, 4'h6 is XOR and 4'h5 is NOT source.
- R6: When `fill_src` is 1, source bits outside the chunk's field are taken as one. When it is 0, they are taken as zero.
- R7: When `clear_dst` is 1, the destination bits inside the chunk's field are cleared before the function is applied.
- R8: Each chunk rewrites only the destination word selected by the destination pointer's bits [5:4]. The other three words keep their values.
- R9: After each chunk the engine checks for termination in this order of priority:
  - result 1 (run complete): the remaining count has reached zero.
  - result 2 (both exhausted): both pointers have wrapped to zero.
  - result 3 (source exhausted): only the source pointer is zero.
  - result 4 (destination exhausted): only the destination pointer is zero.
  - Otherwise the engine processes another chunk.
- R10: `done` is high for exactly one cycle, the cycle after the last chunk, with `busy` low. `result`, `loop_cnt` and `dst_out` then hold their values until the next start.
- R11: After each chunk, both pointers advance by the chunk length modulo 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| src_qw | input | 64 | Source quadword, four 16-bit words |
| dst_qw | input | 64 | Initial destination quadword |
| src_ptr | input | 6 | Source bit pointer |
| dst_ptr | input | 6 | Destination bit pointer |
| run_len | input | 7 | Number of bits to transfer, 1 to 64 |
| func | input | 4 | Truth table of the combining function |
| fill_src | input | 1 | Force source background bits to one |
| clear_dst | input | 1 | Clear destination field before combining |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| result | output | 3 | Termination code (1 to 4) |
| loop_cnt | output | 16 | Chunks processed in the current or last run |
| dst_out | output | 64 | Current destination quadword |

## Verification
The assertions assume that `run_len` is between 1 and 64 whenever a start is accepted. Without that, the remaining count could start at zero and the chunk length would fall outside 1 to 16. Every stimulus vector and directed test drives a length in that range. The inputs change only on the falling clock edge. The assertions also assume that `start` lasts one cycle when the engine is idle. The single deliberate overlap of `start` with `busy` is used only to show that the request is ignored.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_WORD_W = 16;
    localparam int BB_WORDS  = 4;
    localparam int BB_LOOP_W = 16;

    typedef enum logic [2:0] {
        RES_NONE = 3'd0,
        RES_ITEM = 3'd1,
        RES_BOTH = 3'd2,
        RES_SRC  = 3'd3,
        RES_DST  = 3'd4
    } bb_res_e;

endpackage

// File: rtl/bb_chunk_len.sv
module bb_chunk_len #(
    parameter int WORD_W = 16,
    parameter int OFF_W  = 4,
    parameter int CNT_W  = 7,
    parameter int LEN_W  = 5
) (
    input  logic [OFF_W-1:0] src_off,
    input  logic [OFF_W-1:0] dst_off,
    input  logic [CNT_W-1:0] cnt_neg,
    output logic [LEN_W-1:0] len
);
    logic [LEN_W-1:0] src_left;
    logic [LEN_W-1:0] dst_left;
    logic [LEN_W-1:0] word_min;
    logic [CNT_W-1:0] remaining;

    assign src_left  = LEN_W'(WORD_W) - LEN_W'(src_off);
    assign dst_left  = LEN_W'(WORD_W) - LEN_W'(dst_off);
    assign remaining = CNT_W'(0) - cnt_neg;
    assign word_min  = (src_left < dst_left) ? src_left : dst_left;

    always_comb begin
        if (remaining < CNT_W'(word_min)) begin
            len = remaining[LEN_W-1:0];
        end else begin
            len = word_min;
        end
    end
endmodule

// File: rtl/bb_word_op.sv
module bb_word_op #(
    parameter int WORD_W = 16,
    parameter int OFF_W  = 4,
    parameter int LEN_W  = 5
) (
    input  logic [WORD_W-1:0] src_word,
    input  logic [WORD_W-1:0] dst_word,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [OFF_W-1:0]  dst_off,
    input  logic [LEN_W-1:0]  len,
    input  logic [3:0]        func,
    input  logic              fill,
    input  logic              clr,
    output logic [WORD_W-1:0] new_word
);
    localparam int WIDE_W = 2 * WORD_W;

    logic [WIDE_W-1:0] one_w;
    logic [WIDE_W-1:0] len_ones;
    logic [WIDE_W-1:0] mask_w;
    logic [WIDE_W-1:0] field_w;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] s_eff;
    logic [WORD_W-1:0] d_eff;

    assign one_w    = WIDE_W'(1);
    assign len_ones = (one_w << len) - one_w;
    assign mask_w   = len_ones << dst_off;
    assign mask     = mask_w[WORD_W-1:0];
    assign field_w  = ((WIDE_W'(src_word) >> src_off) & len_ones) << dst_off;
    assign aligned  = field_w[WORD_W-1:0];
    assign s_eff    = fill ? (aligned | ~mask) : aligned;
    assign d_eff    = clr ? (dst_word & ~mask) : dst_word;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign new_word[b] = func[{d_eff[b], s_eff[b]}];
    end
endmodule

// File: rtl/bb_engine.sv
module bb_engine
    import bb_pkg::*;
#(
    parameter int WORD_W = BB_WORD_W,
    parameter int WORDS  = BB_WORDS,
    parameter int LOOP_W = BB_LOOP_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [WORD_W*WORDS-1:0]             src_qw,
    input  logic [WORD_W*WORDS-1:0]             dst_qw,
    input  logic [$clog2(WORD_W*WORDS)-1:0]     src_ptr,
    input  logic [$clog2(WORD_W*WORDS)-1:0]     dst_ptr,
    input  logic [$clog2(WORD_W*WORDS):0]       run_len,
    input  logic [3:0]                          func,
    input  logic                                fill_src,
    input  logic                                clear_dst,
    output logic                                busy,
    output logic                                done,
    output logic [2:0]                          result,
    output logic [LOOP_W-1:0]                   loop_cnt,
    output logic [WORD_W*WORDS-1:0]             dst_out
);
    localparam int QW_W  = WORD_W * WORDS;
    localparam int OFF_W = $clog2(WORD_W);
    localparam int SEL_W = $clog2(WORDS);
    localparam int PTR_W = OFF_W + SEL_W;
    localparam int CNT_W = PTR_W + 1;
    localparam int LEN_W = OFF_W + 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        bb_res_e           code;
        logic [PTR_W-1:0]  sp;
        logic [PTR_W-1:0]  dp;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        func;
        logic              fill;
        logic              clr;
        logic [LOOP_W-1:0] iters;
        logic [QW_W-1:0]   src;
        logic [QW_W-1:0]   dst;
    } state_t;

    state_t st_q, st_d;

    logic [WORD_W-1:0] src_words [WORDS];
    logic [WORD_W-1:0] dst_words [WORDS];
    logic [SEL_W-1:0]  src_sel, dst_sel;
    logic [OFF_W-1:0]  src_off, dst_off;
    logic [LEN_W-1:0]  chunk_len;
    logic [WORD_W-1:0] new_word;
    logic [PTR_W-1:0]  sp_next, dp_next;
    logic [CNT_W-1:0]  cnt_next;

    for (genvar w = 0; w < WORDS; w++) begin : g_split
        assign src_words[w] = st_q.src[w*WORD_W +: WORD_W];
        assign dst_words[w] = st_q.dst[w*WORD_W +: WORD_W];
    end

    assign src_sel = st_q.sp[PTR_W-1:OFF_W];
    assign dst_sel = st_q.dp[PTR_W-1:OFF_W];
    assign src_off = st_q.sp[OFF_W-1:0];
    assign dst_off = st_q.dp[OFF_W-1:0];

    bb_chunk_len #(
        .WORD_W (WORD_W),
        .OFF_W  (OFF_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) i_len (
        .src_off (src_off),
        .dst_off (dst_off),
        .cnt_neg (st_q.cnt),
        .len     (chunk_len)
    );

    bb_word_op #(
        .WORD_W (WORD_W),
        .OFF_W  (OFF_W),
        .LEN_W  (LEN_W)
    ) i_op (
        .src_word (src_words[src_sel]),
        .dst_word (dst_words[dst_sel]),
        .src_off  (src_off),
        .dst_off  (dst_off),
        .len      (chunk_len),
        .func     (st_q.func),
        .fill     (st_q.fill),
        .clr      (st_q.clr),
        .new_word (new_word)
    );

    assign sp_next  = st_q.sp + PTR_W'(chunk_len);
    assign dp_next  = st_q.dp + PTR_W'(chunk_len);
    assign cnt_next = st_q.cnt + CNT_W'(chunk_len);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.code  = RES_NONE;
                st_d.sp    = src_ptr;
                st_d.dp    = dst_ptr;
                st_d.cnt   = CNT_W'(0) - run_len;
                st_d.func  = func;
                st_d.fill  = fill_src;
                st_d.clr   = clear_dst;
                st_d.iters = '0;
                st_d.src   = src_qw;
                st_d.dst   = dst_qw;
            end
        end else begin
            st_d.sp    = sp_next;
            st_d.dp    = dp_next;
            st_d.cnt   = cnt_next;
            st_d.iters = st_q.iters + LOOP_W'(1);
            for (int w = 0; w < WORDS; w++) begin
                if (SEL_W'(w) == dst_sel) begin
                    st_d.dst[w*WORD_W +: WORD_W] = new_word;
                end
            end
            if (cnt_next == '0) begin
                st_d.code = RES_ITEM;
            end else if (sp_next == '0 && dp_next == '0) begin
                st_d.code = RES_BOTH;
            end else if (sp_next == '0) begin
                st_d.code = RES_SRC;
            end else if (dp_next == '0) begin
                st_d.code = RES_DST;
            end
            if (st_d.code != RES_NONE) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign result   = st_q.code;
    assign loop_cnt = st_q.iters;
    assign dst_out  = st_q.dst;
endmodule

// File: rtl/bb_engine_chk.sv
module bb_engine_chk #(
    parameter int LEN_W  = 5,
    parameter int WORD_W = 16,
    parameter int LOOP_W = 16,
    parameter int QW_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [2:0]        result,
    input logic [LOOP_W-1:0] loop_cnt,
    input logic [QW_W-1:0]   dst_out,
    input logic [LEN_W-1:0]  chunk
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result >= 3'd1 && result <= 3'd4));

    // R3
    iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> loop_cnt == $past(loop_cnt) + LOOP_W'(1));

    // R3
    chunk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (chunk != '0 && chunk <= LEN_W'(WORD_W)));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && loop_cnt == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(dst_out) && $stable(loop_cnt) && $stable(result)));
endmodule

bind bb_engine bb_engine_chk #(
    .LEN_W  (LEN_W),
    .WORD_W (WORD_W),
    .LOOP_W (LOOP_W),
    .QW_W   (QW_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .loop_cnt (loop_cnt),
    .dst_out  (dst_out),
    .chunk    (chunk_len)
);

// File: tb/test_bb_engine.sv
`timescale 1ns/100ps
module test_bb_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] src_qw = '0;
    logic [63:0] dst_qw = '0;
    logic [5:0]  src_ptr = '0;
    logic [5:0]  dst_ptr = '0;
    logic [6:0]  run_len = 7'd1;
    logic [3:0]  func = '0;
    logic        fill_src = 1'b0;
    logic        clear_dst = 1'b0;
    logic        busy, done;
    logic [2:0]  result;
    logic [15:0] loop_cnt;
    logic [63:0] dst_out;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    bb_engine i_bb_engine (
        .clk (clk), .rst_n (rst_n), .start (start),
        .src_qw (src_qw), .dst_qw (dst_qw),
        .src_ptr (src_ptr), .dst_ptr (dst_ptr), .run_len (run_len),
        .func (func), .fill_src (fill_src), .clear_dst (clear_dst),
        .busy (busy), .done (done), .result (result),
        .loop_cnt (loop_cnt), .dst_out (dst_out)
    );

    // {src, dst, sptr, dptr, len, func, fill, clr, exp_code, exp_iters}
    localparam int VN = 12;
    localparam logic [171:0] VECS [VN] = '{
        // R3 R9: one aligned word copy, code 1
        {64'h1234_5678_9ABC_DEF0, 64'h0, 6'd0,  6'd16, 7'd16, 4'hA, 1'b0, 1'b0, 3'd1, 16'd1},
        // R3 R4: three chunks split by both boundaries
        {64'hCAFE_F00D_BEEF_1357, 64'hFFFF_0000_FFFF_0000, 6'd4, 6'd8, 7'd20, 4'hA, 1'b0, 1'b0, 3'd1, 16'd3},
        // R9 R11: source wraps first, code 3
        {64'hA5A5_5A5A_0F0F_F0F0, 64'h1111_2222_3333_4444, 6'd60, 6'd0, 7'd10, 4'hA, 1'b0, 1'b0, 3'd3, 16'd1},
        // R9 R11: destination wraps first, code 4
        {64'h0123_4567_89AB_CDEF, 64'h0, 6'd0, 6'd56, 7'd20, 4'hE, 1'b0, 1'b0, 3'd4, 16'd1},
        // R9: both wrap together, code 2
        {64'hFEDC_BA98_7654_3210, 64'h5555_AAAA_5555_AAAA, 6'd48, 6'd48, 7'd30, 4'h6, 1'b0, 1'b0, 3'd2, 16'd1},
        // R9: count priority over wrap, code 1
        {64'hFEDC_BA98_7654_3210, 64'h5555_AAAA_5555_AAAA, 6'd48, 6'd48, 7'd16, 4'hA, 1'b0, 1'b0, 3'd1, 16'd1},
        // R3: full 64-bit run
        {64'h8000_0001_7FFE_C3C3, 64'h0, 6'd0, 6'd0, 7'd64, 4'hA, 1'b0, 1'b0, 3'd1, 16'd4},
        // R6 R5: fill with AND keeps background
        {64'h0000_0000_0000_0A28, 64'hFFFF_FFFF_FFFF_FFFF, 6'd3, 6'd5, 7'd6, 4'h8, 1'b1, 1'b0, 3'd1, 16'd1},
        // R7 R5: clear then OR
        {64'h3C3C_C3C3_0FF0_F00F, 64'hFFFF_FFFF_FFFF_FFFF, 6'd10, 6'd2, 7'd9, 4'hE, 1'b0, 1'b1, 3'd1, 16'd2},
        // R5 R6 R7: XOR with fill and clear, source exhausted
        {64'h9182_7364_5546_3728, 64'h1357_9BDF_2468_ACE0, 6'd33, 6'd17, 7'd40, 4'h6, 1'b1, 1'b1, 3'd3, 16'd2},
        // R5: constant one function
        {64'h0, 64'h0, 6'd7, 6'd7, 7'd3, 4'hF, 1'b0, 1'b0, 3'd1, 16'd1},
        // R5 R8: NOT source across three chunks, code 4
        {64'h6B6B_B6B6_1248_8421, 64'h7777_8888_9999_AAAA, 6'd20, 6'd40, 7'd25, 4'h5, 1'b0, 1'b0, 3'd4, 16'd3}
    };

    function automatic logic [63:0] ref_dst(
        input logic [63:0] s, input logic [63:0] d, input int sp0, input int dp0,
        input int len, input logic [3:0] f, input logic fl, input logic cl);
        logic [63:0] r = d;
        int sp = sp0, dp = dp0, rem = len;
        for (int guard = 0; guard < 100; guard++) begin
            int so = sp % 16, dof = dp % 16, n;
            int sw = sp / 16, dw = dp / 16;
            logic [15:0] nw;
            n = 16 - so;
            if (16 - dof < n) n = 16 - dof;
            if (rem < n) n = rem;
            for (int i = 0; i < 16; i++) begin
                logic inm, sb, db;
                inm = (i >= dof) && (i < dof + n);
                sb = inm ? s[sw*16 + so + i - dof] : fl;
                db = r[dw*16 + i];
                if (inm && cl) db = 1'b0;
                nw[i] = f[{db, sb}];
            end
            r[dw*16 +: 16] = nw;
            sp = (sp + n) % 64;
            dp = (dp + n) % 64;
            rem = rem - n;
            if (rem == 0 || sp == 0 || dp == 0) break;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [63:0] s, input logic [63:0] d, input logic [5:0] sp,
                          input logic [5:0] dp, input logic [6:0] len, input logic [3:0] f,
                          input logic fl, input logic cl);
        src_qw = s; dst_qw = d; src_ptr = sp; dst_ptr = dp; run_len = len;
        func = f; fill_src = fl; clear_dst = cl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        bit seen;
        logic [171:0] v;
        logic [63:0] exp_d;
        repeat (3) @(negedge clk);
        // R1: outputs during and after reset
        check("R1 reset busy/done/result", {61'd0, busy, done, result[0]}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle result", {61'd0, result}, 64'd0);
        check("R1 idle loop_cnt", {48'd0, loop_cnt}, 64'd0);
        check("R1 idle dst_out", dst_out, 64'd0);

        for (int i = 0; i < VN; i++) begin
            v = VECS[i];
            exp_d = ref_dst(v[171:108], v[107:44], int'(v[43:38]), int'(v[37:32]),
                            int'(v[31:25]), v[24:21], v[20], v[19]);
            launch(v[171:108], v[107:44], v[43:38], v[37:32], v[31:25], v[24:21], v[20], v[19]);
            check("R2 busy after start", {63'd0, busy}, 64'd1);
            wait_done(seen);
            check("R10 done seen", {63'd0, seen}, 64'd1);
            check("R9 result code", {61'd0, result}, {61'd0, v[18:16]});
            check("R3 chunk count", {48'd0, loop_cnt}, {48'd0, v[15:0]});
            check("R4/R5/R6/R7/R8/R11 destination", dst_out, exp_d);
            @(negedge clk);
            check("R10 done one cycle", {63'd0, done}, 64'd0);
            check("R10 result held", {61'd0, result}, {61'd0, v[18:16]});
        end

        // R2: start while busy is ignored
        launch(64'hDEAD_BEEF_0BAD_F00D, 64'h0, 6'd0, 6'd0, 7'd64, 4'hA, 1'b0, 1'b0);
        @(negedge clk);
        src_qw = 64'h0; func = 4'h0; run_len = 7'd1; src_ptr = 6'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check("R2 ignored start code", {61'd0, result}, 64'd1);
        check("R2 ignored start iters", {48'd0, loop_cnt}, 64'd4);
        check("R2 ignored start data", dst_out, 64'hDEAD_BEEF_0BAD_F00D);
        repeat (3) @(negedge clk);
        check("R10 outputs held while idle", dst_out, 64'hDEAD_BEEF_0BAD_F00D);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule